// File: doc/BRIEF.md
# Cartridge Bank-Select Write Latch

This block holds the bank number for a cartridge on an 8-bit CPU bus. It decodes the upper half of the address space from the high address bit and the bus phase clock. The result is an active-low ROM select, low only while both the high address bit and the phase clock are high. A CPU write anywhere in that upper half stores the low bits of the data byte as the new bank number. Reads in that range and accesses below it leave the bank unchanged.

The write is taken at the trailing edge of the bus phase, when ROM select rises again. It is not taken at the leading edge, because only the address and read/write are valid there. The data bus settles late in the phase. A fast free-running system clock samples all bus pins through a two-stage synchronizer, so the whole block is one synchronous clock domain. The rising edge of the synchronized select is found by comparing the current sample with the previous one. The data and read/write values loaded are the samples from one system clock before that edge, which is the last sample taken while the phase was still high.

Top module: `cart_bank_latch`

## Requirements
- R1: `rom_sel_n` is the combinational value NOT(`addr_hi` AND `phase_clk`): it is 0 only while both inputs are 1.
- R2: A bus cycle with `addr_hi`=1 and `rd_wr_n`=0 sets `bank` to the low BANK_W bits of `data_bus` as it stood at the end of the phase, even if a different value was driven earlier in the same phase.
- R3: `bank` does not change while `phase_clk` is still high, even when the data of the write has been stable for several system clocks.
- R4: A bus cycle with `addr_hi`=1 and `rd_wr_n`=1 (read) leaves `bank` unchanged.
- R5: A bus cycle with `addr_hi`=0 leaves `bank` unchanged, whatever the values of `rd_wr_n` and the data.
- R6: Data bits at and above BANK_W (default bits 7:4) have no effect on `bank`.
- R7: `bank` reads 0 at the first system clock edge with `rst` high, whether or not the block is idle.
- R8: `bank` takes its new value at the third rising `clk` edge after `phase_clk` falls, and keeps its old value through the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| phase_clk | input | 1 | CPU bus phase clock; high during the valid part of a cycle |
| addr_hi | input | 1 | Highest CPU address bit |
| rd_wr_n | input | 1 | CPU read/write: 1 for a read, 0 for a write |
| data_bus | input | 8 | CPU data bus |
| rom_sel_n | output | 1 | Active-low ROM select for the upper address half |
| bank | output | BANK_W | Registered bank number (default 4 bits) |

## Verification
Each bus cycle drives a throwaway data value early in the phase and the real value late in the phase. A design that captured at the leading edge, or on read/write, would store the early value. The bench reads `bank` while the phase is still high, so a design that updated too soon fails there. It also counts the exact system clock on which the update appears, which catches a missing or extra synchronizer stage. Reads, lower-half writes and data bytes with the upper nibble set are mixed into the sequence, so a design that ignored the read/write qualifier, the address bit or the width truncation would show a wrong bank. A reset during activity must clear the register.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              m2;
    logic              a15;
    logic              rw;
    logic [DATA_W-1:0] data;
  } bus_sample_t;

  localparam int SAMPLE_W = $bits(bus_sample_t);
endpackage

// File: rtl/cbl_sync.sv
module cbl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cbl_edge_ctl.sv
module cbl_edge_ctl
  import cbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bus_sample_t       smp,
  output logic              load,
  output logic [DATA_W-1:0] ld_data
);
  logic              sel_now;
  logic              sel_q;
  logic              rw_prev;
  logic [DATA_W-1:0] data_prev;

  // select as seen in the synchronized domain (active low)
  assign sel_now = ~(smp.m2 & smp.a15);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= 1'b1;
      rw_prev   <= 1'b1;
      data_prev <= '0;
    end else begin
      sel_q     <= sel_now;
      rw_prev   <= smp.rw;
      data_prev <= smp.data;
    end
  end

  // trailing edge of the phase: select returns high; qualified by a write
  assign load    = sel_now & ~sel_q & ~rw_prev;
  assign ld_data = data_prev;

  assert_load_after_phase_R3: assert property (@(posedge clk) disable iff (rst)
    load |-> (!smp.m2 && $past(smp.m2 && smp.a15)));

  assert_load_write_only_R4: assert property (@(posedge clk) disable iff (rst)
    load |-> !$past(smp.rw));
endmodule

// File: rtl/cbl_bank_reg.sv
module cbl_bank_reg
  import cbl_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst)       bank <= '0;
    else if (load) bank <= ld_data[BANK_W-1:0];
  end

  generate
    if (BANK_W < DATA_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^ld_data[DATA_W-1:BANK_W];
    end
  endgenerate

  assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (bank == $past(ld_data[BANK_W-1:0])));

  assert_hold_no_load_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(bank));
endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cbl_pkg::*;
#(
  parameter int BANK_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_clk,
  input  logic              addr_hi,
  input  logic              rd_wr_n,
  input  logic [DATA_W-1:0] data_bus,
  output logic              rom_sel_n,
  output logic [BANK_W-1:0] bank
);
  bus_sample_t       raw;
  bus_sample_t       smp;
  logic [SAMPLE_W-1:0] smp_vec;
  logic              load;
  logic [DATA_W-1:0] ld_data;

  // glue decode straight from the pins; the bus needs it within the phase
  assign rom_sel_n = ~(addr_hi & phase_clk);

  assign raw.m2   = phase_clk;
  assign raw.a15  = addr_hi;
  assign raw.rw   = rd_wr_n;
  assign raw.data = data_bus;

  cbl_sync #(.W(SAMPLE_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (smp_vec)
  );

  assign smp = bus_sample_t'(smp_vec);

  cbl_edge_ctl u_ctl (
    .clk     (clk),
    .rst     (rst),
    .smp     (smp),
    .load    (load),
    .ld_data (ld_data)
  );

  cbl_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ld_data (ld_data),
    .bank    (bank)
  );

  always_comb begin
    assert_param_width_R6: assert (BANK_W >= 1 && BANK_W <= DATA_W);
  end
endmodule

// File: tb/sim_cart_bank_latch.sv
module sim_cart_bank_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phase_clk = 1'b0;
  logic       addr_hi = 1'b0;
  logic       rd_wr_n = 1'b1;
  logic [7:0] data_bus = 8'h00;
  logic       rom_sel_n;
  logic [3:0] bank;

  int checks = 0;
  int errors = 0;
  logic [3:0] cur = 4'h0;

  always #10 clk = ~clk;

  cart_bank_latch u0 (
    .clk(clk), .rst(rst), .phase_clk(phase_clk), .addr_hi(addr_hi),
    .rd_wr_n(rd_wr_n), .data_bus(data_bus), .rom_sel_n(rom_sel_n), .bank(bank)
  );

  typedef struct packed {
    logic       a15;
    logic       rw;
    logic [7:0] early;
    logic [7:0] late;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h05, 8'h0A, 4'hA},
    '{1'b1, 1'b1, 8'h00, 8'h03, 4'hA},
    '{1'b0, 1'b0, 8'h02, 8'h07, 4'hA},
    '{1'b1, 1'b0, 8'h0C, 8'hF3, 4'h3},
    '{1'b1, 1'b0, 8'h11, 8'h8E, 4'hE},
    '{1'b0, 1'b1, 8'h0F, 8'h01, 4'hE},
    '{1'b1, 1'b0, 8'h09, 8'h00, 4'h0},
    '{1'b1, 1'b0, 8'h3F, 8'h3F, 4'hF}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic bus_cycle(input logic a15, input logic rw, input logic [7:0] early,
                           input logic [7:0] late, input logic [3:0] exp, input string tag);
    @(negedge clk);
    addr_hi = a15; rd_wr_n = rw; data_bus = early; phase_clk = 1'b1;
    repeat (3) @(negedge clk);
    check(rom_sel_n == !a15, "R1", rom_sel_n, !a15);
    data_bus = late;
    repeat (4) @(negedge clk);
    check(bank == cur, "R3", bank, cur);
    phase_clk = 1'b0;
    @(negedge clk);
    check(rom_sel_n == 1'b1, "R1", rom_sel_n, 1);
    data_bus = 8'h55; addr_hi = 1'b0; rd_wr_n = 1'b1;
    repeat (5) @(negedge clk);
    check(bank == exp, tag, bank, exp);
    cur = exp;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(bank == 4'h0, "R7", bank, 0);
    check(rom_sel_n == 1'b1, "R1", rom_sel_n, 1);
    rst = 1'b0;
    @(negedge clk);
    addr_hi = 1'b1;
    @(negedge clk);
    check(rom_sel_n == 1'b1, "R1", rom_sel_n, 1);
    addr_hi = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      if (!VECS[i].a15)               tag = "R5";
      else if (VECS[i].rw)            tag = "R4";
      else if (VECS[i].late[7:4] != 0) tag = "R6";
      else                            tag = "R2";
      bus_cycle(VECS[i].a15, VECS[i].rw, VECS[i].early, VECS[i].late, VECS[i].exp, tag);
    end

    // R8: exact update latency after the phase falls
    @(negedge clk);
    addr_hi = 1'b1; rd_wr_n = 1'b0; data_bus = 8'h06; phase_clk = 1'b1;
    repeat (6) @(negedge clk);
    phase_clk = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(bank == cur, "R8", bank, cur);
    @(negedge clk);
    check(bank == 4'h6, "R8", bank, 6);
    cur = 4'h6;
    addr_hi = 1'b0; rd_wr_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset during activity clears the register
    addr_hi = 1'b1; phase_clk = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(bank == 4'h0, "R7", bank, 0);
    rst = 1'b0; phase_clk = 1'b0; addr_hi = 1'b0;
    cur = 4'h0;
    repeat (5) @(negedge clk);
    check(bank == 4'h0, "R7", bank, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule